// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit RISC-V compressed instruction into the single RV32I instruction that does the same work. A fetch stage hands it one instruction word at a time. If the two low bits of the word are not `11`, the low half is read as a compressed encoding. The block looks up its quadrant and funct3, rebuilds the scattered immediate into the field order of the target format, and maps any 3-bit register field onto x8..x15. If the two low bits are `11`, the word is already a full instruction and goes out untouched.

Each compressed opcode has exactly one fixed expansion. A compressed encoding outside the supported group sets an illegal flag and leaves a word of all zeros. The supported group is: add, mv, jr, jalr, li, lui, addi, slli, lw, sw, and, or, xor, sub, beqz, bnez, srli, srai, andi, j and jal.

Both sides use valid/ready handshakes, with one output register between them. A word is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and flag hold steady and no new input is taken. The result of an accepted word appears one cycle later.

Top module: `rvc_expander`

## Requirements
- R1: A word whose bits [1:0] are `11` leaves unchanged in all 32 bits, with the illegal flag low.
- R2: In the load, store, register-register arithmetic and branch-on-zero forms, each 3-bit register field f selects register 8+f (`{2'b01,f}`).
- R3: Quadrant `10` with bits [15:12] = `1000`: a nonzero rs2 in bits [6:2] gives `add rd, x0, rs2`. A zero rs2 with a nonzero rs1 in bits [11:7] gives `jalr x0, 0(rs1)`. A zero rs2 with a zero rs1 is illegal.
- R4: Quadrant `10` with bits [15:12] = `1001`: a nonzero rs2 gives `add rd, rd, rs2`. A zero rs2 with a nonzero rs1 gives `jalr x1, 0(rs1)`. Both zero is illegal.
- R5: Quadrant `01` with funct3 `000`, `010`, and `100` with bits [11:10] = `10` give `addi rd,rd,imm`, `addi rd,x0,imm` and `andi rd',rd',imm`. The 6-bit immediate {bit12, bits[6:2]} is sign-extended to 12 bits.
- R6: Quadrant `01` with funct3 `011` and rd other than x2 gives `lui rd, imm`. U imm[31:12] is {bit12, bits[6:2]} sign-extended to 20 bits. rd = x2 is illegal.
- R7: Quadrant `10` with funct3 `000` gives slli (funct7 `0000000`). Quadrant `01` with funct3 `100` and bits [11:10] = `00` or `01` gives srli or srai (funct7 `0000000` or `0100000`). The shift amount is bits [6:2]. Bit 12 set is illegal for all three.
- R8: Quadrant `00` with funct3 `010` gives lw, and with funct3 `110` gives sw. The zero-extended offset has offset[5:3] = bits[12:10], offset[2] = bit6 and offset[6] = bit5.
- R9: Quadrant `01` with funct3 `100`, bits [12:10] = `011`: bits [6:5] of `11`, `10`, `01`, `00` give and, or, xor, sub. sub uses funct7 `0100000`. Bit 12 set is illegal.
- R10: Quadrant `01` with funct3 `110` or `111` gives `beq` or `bne rs1', x0, off`. The offset has off[8] = bit12, off[4:3] = bits[11:10], off[7:6] = bits[6:5], off[2:1] = bits[4:3] and off[5] = bit2, and is sign-extended.
- R11: Quadrant `01` with funct3 `101` or `001` gives `jal x0` or `jal x1, off`. Bits [12:2] carry off[11|4|9:8|10|6|7|3:1|5], and the offset is sign-extended.
- R12: Any other 16-bit encoding sets the illegal flag and gives an output word of zero.
- R13: An accepted word appears at the output on the next cycle. While `out_valid && !out_ready`, `in_ready` is low and the output holds.
- R14: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 32 | Compressed instruction in [15:0], or a full instruction |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Expanded or passed-through instruction |
| out_illegal | output | 1 | Compressed encoding outside the supported group |

## Verification
The bench runs every one of the 65,536 values of the low half-word through the block. Each result is compared against a model that works out the immediate as an integer, then encodes it with generic I, S, SB, U and UJ packers.

This sweep catches several kinds of error:
- An immediate bit swapped in the jump or branch scramble would give a wrong target.
- A sign extension taken from the wrong bit would flip far targets to the wrong direction.
- A missing x8 bias would point at x0..x7.
- A reversed funct7 on sub or srai would silently add or shift logically.

The register-zero splits between mv/jr and add/jalr, the x2 hole in lui, and bit 12 on the shifts are reached by the same sweep. A design that mishandles them would emit a jump for a move, or accept a reserved code. A directed stall run checks that the output is held rather than overwritten under back-pressure.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int ILEN = 32;
  localparam int CLEN = 16;

  localparam logic [6:0] OP_REG    = 7'b0110011;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_JALR   = 7'b1100111;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_LUI    = 7'b0110111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef struct packed {
    logic [ILEN-1:0] word;
    logic            bad;
  } xlat_t;

  localparam xlat_t XLAT_BAD = '{word: '0, bad: 1'b1};

  // short register field -> x8..x15
  function automatic logic [4:0] prime_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic xlat_t pack_r(input logic [6:0] f7, input logic [4:0] rs2,
                                   input logic [4:0] rs1, input logic [2:0] f3,
                                   input logic [4:0] rd, input logic [6:0] op);
    return '{word: {f7, rs2, rs1, f3, rd, op}, bad: 1'b0};
  endfunction

  function automatic xlat_t pack_i(input logic [11:0] imm, input logic [4:0] rs1,
                                   input logic [2:0] f3, input logic [4:0] rd,
                                   input logic [6:0] op);
    return '{word: {imm, rs1, f3, rd, op}, bad: 1'b0};
  endfunction
endpackage

// File: rtl/rvc_quad0.sv
module rvc_quad0
  import rvc_pkg::*;
(
  input  logic [CLEN-1:0] c,
  output xlat_t           res
);
  logic [11:0] off;

  always_comb begin
    off = {5'b0, c[5], c[12:10], c[6], 2'b00};
    res = XLAT_BAD;
    case (c[15:13])
      3'b010: res = pack_i(off, prime_reg(c[9:7]), 3'b010, prime_reg(c[4:2]), OP_LOAD);
      3'b110: res = '{word: {off[11:5], prime_reg(c[4:2]), prime_reg(c[9:7]), 3'b010,
                             off[4:0], OP_STORE}, bad: 1'b0};
      default: res = XLAT_BAD;
    endcase
  end
endmodule

// File: rtl/rvc_quad1.sv
module rvc_quad1
  import rvc_pkg::*;
(
  input  logic [CLEN-1:0] c,
  output xlat_t           res
);
  logic [11:0] imm12;
  logic [19:0] imm20;
  logic [20:0] jo;
  logic [12:0] bo;
  logic [4:0]  rdf, rdp, rs2p;
  logic [2:0]  ca_f3;
  logic [6:0]  ca_f7;

  always_comb begin
    imm12 = {{6{c[12]}}, c[12], c[6:2]};
    imm20 = {{14{c[12]}}, c[12], c[6:2]};
    jo    = {{9{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
    bo    = {{4{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
    rdf   = c[11:7];
    rdp   = prime_reg(c[9:7]);
    rs2p  = prime_reg(c[4:2]);
    ca_f7 = F7_BASE;
    case (c[6:5])
      2'b00:   begin ca_f3 = 3'b000; ca_f7 = F7_ALT; end
      2'b01:   ca_f3 = 3'b100;
      2'b10:   ca_f3 = 3'b110;
      default: ca_f3 = 3'b111;
    endcase

    res = XLAT_BAD;
    case (c[15:13])
      3'b000: res = pack_i(imm12, rdf, 3'b000, rdf, OP_IMM);
      3'b001: res = '{word: {jo[20], jo[10:1], jo[11], jo[19:12], 5'd1, OP_JAL}, bad: 1'b0};
      3'b010: res = pack_i(imm12, 5'd0, 3'b000, rdf, OP_IMM);
      3'b011: if (rdf != 5'd2) res = '{word: {imm20, rdf, OP_LUI}, bad: 1'b0};
      3'b100: begin
        case (c[11:10])
          2'b00: if (!c[12]) res = pack_r(F7_BASE, c[6:2], rdp, 3'b101, rdp, OP_IMM);
          2'b01: if (!c[12]) res = pack_r(F7_ALT, c[6:2], rdp, 3'b101, rdp, OP_IMM);
          2'b10: res = pack_i(imm12, rdp, 3'b111, rdp, OP_IMM);
          default: if (!c[12]) res = pack_r(ca_f7, rs2p, rdp, ca_f3, rdp, OP_REG);
        endcase
      end
      3'b101: res = '{word: {jo[20], jo[10:1], jo[11], jo[19:12], 5'd0, OP_JAL}, bad: 1'b0};
      default: res = '{word: {bo[12], bo[10:5], 5'd0, rdp, {2'b00, c[13]}, bo[4:1], bo[11],
                              OP_BRANCH}, bad: 1'b0};
    endcase
  end
endmodule

// File: rtl/rvc_quad2.sv
module rvc_quad2
  import rvc_pkg::*;
(
  input  logic [CLEN-1:0] c,
  output xlat_t           res
);
  logic [4:0] rdf, rs2f;
  logic [4:0] link;

  always_comb begin
    rdf  = c[11:7];
    rs2f = c[6:2];
    link = {4'd0, c[12]};
    res  = XLAT_BAD;
    case (c[15:13])
      3'b000: if (!c[12]) res = pack_r(F7_BASE, rs2f, rdf, 3'b001, rdf, OP_IMM);
      3'b100: begin
        if (rs2f != 5'd0)
          res = pack_r(F7_BASE, rs2f, c[12] ? rdf : 5'd0, 3'b000, rdf, OP_REG);
        else if (rdf != 5'd0)
          res = pack_i(12'd0, rdf, 3'b000, link, OP_JALR);
      end
      default: res = XLAT_BAD;
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ILEN-1:0] in_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ILEN-1:0] out_word,
  output logic            out_illegal
);
  xlat_t r_q0, r_q1, r_q2, nxt;

  rvc_quad0 u_q0 (.c(in_word[CLEN-1:0]), .res(r_q0));
  rvc_quad1 u_q1 (.c(in_word[CLEN-1:0]), .res(r_q1));
  rvc_quad2 u_q2 (.c(in_word[CLEN-1:0]), .res(r_q2));

  always_comb begin
    case (in_word[1:0])
      2'b00:   nxt = r_q0;
      2'b01:   nxt = r_q1;
      2'b10:   nxt = r_q2;
      default: nxt = '{word: in_word, bad: 1'b0};
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word    <= nxt.word;
        out_illegal <= nxt.bad;
      end
    end
  end
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_illegal
);
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_word[1:0] == 2'b11) |=> (out_word == $past(in_word) && !out_illegal));

  // R12
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_word == 32'd0));

  // R12
  legal_full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_word[1:0] == 2'b11));

  // R13
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_illegal)));

  // R13
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R14
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind rvc_expander rvc_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_illegal(out_illegal)
);

// File: tb/rvc_expander_tb.sv
module rvc_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic        pend = 1'b0;
  logic [31:0] exp_w;
  logic        exp_i;
  string       exp_tag;

  always #10 clk = ~clk;

  rvc_expander u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_illegal(out_illegal)
  );

  function automatic logic [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd, int op);
    return 32'((f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
  endfunction
  function automatic logic [31:0] enc_i(int imm, int rs1, int f3, int rd, int op);
    return 32'(((imm & 12'hfff) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
  endfunction
  function automatic logic [31:0] enc_s(int imm, int rs2, int rs1, int f3, int op);
    return 32'((((imm >> 5) & 127) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12)
               | ((imm & 31) << 7) | op);
  endfunction
  function automatic logic [31:0] enc_b(int imm, int rs1, int f3);
    return 32'((((imm >> 12) & 1) << 31) | (((imm >> 5) & 63) << 25) | (rs1 << 15)
               | (f3 << 12) | (((imm >> 1) & 15) << 8) | (((imm >> 11) & 1) << 7) | 'h63);
  endfunction
  function automatic logic [31:0] enc_u(int imm20, int rd);
    return 32'(((imm20 & 20'hfffff) << 12) | (rd << 7) | 'h37);
  endfunction
  function automatic logic [31:0] enc_j(int imm, int rd);
    return 32'((((imm >> 20) & 1) << 31) | (((imm >> 1) & 1023) << 21)
               | (((imm >> 11) & 1) << 20) | (((imm >> 12) & 255) << 12) | (rd << 7) | 'h6f);
  endfunction

  // independent reference of the expansion rules
  function automatic void ref_exp(input logic [31:0] w, output logic [31:0] ew,
                                  output logic ill, output string tag);
    logic [15:0] c;
    int f3, rd, rs2, rdp, rs2p, i6, o;
    c    = w[15:0];
    f3   = int'(c[15:13]);
    rd   = int'(c[11:7]);
    rs2  = int'(c[6:2]);
    rdp  = int'(c[9:7]) + 8;
    rs2p = int'(c[4:2]) + 8;
    i6   = int'(c[6:2]) + 32 * int'(c[12]);
    if (c[12]) i6 = i6 - 64;
    ew = 32'd0; ill = 1'b1; tag = "R12";
    if (c[1:0] == 2'b11) begin
      ew = w; ill = 1'b0; tag = "R1";
    end else if (c[1:0] == 2'b00) begin
      o = 8 * int'(c[12:10]) + 4 * int'(c[6]) + 64 * int'(c[5]);
      if (f3 == 2) begin ew = enc_i(o, rdp, 2, rs2p, 3); ill = 0; tag = "R8 R2 lw"; end
      if (f3 == 6) begin ew = enc_s(o, rs2p, rdp, 2, 'h23); ill = 0; tag = "R8 R2 sw"; end
    end else if (c[1:0] == 2'b01) begin
      case (f3)
        0: begin ew = enc_i(i6, rd, 0, rd, 'h13); ill = 0; tag = "R5 addi"; end
        2: begin ew = enc_i(i6, 0, 0, rd, 'h13); ill = 0; tag = "R5 li"; end
        3: if (rd != 2) begin ew = enc_u(i6, rd); ill = 0; tag = "R6 lui"; end
        4: begin
          if (c[11:10] == 2'b10) begin
            ew = enc_i(i6, rdp, 7, rdp, 'h13); ill = 0; tag = "R5 andi";
          end else if (!c[12]) begin
            ill = 0;
            case (int'(c[11:10]))
              0: begin ew = enc_r(0, rs2, rdp, 5, rdp, 'h13); tag = "R7 srli"; end
              1: begin ew = enc_r(32, rs2, rdp, 5, rdp, 'h13); tag = "R7 srai"; end
              default: begin
                tag = "R9 R2 alu";
                case (int'(c[6:5]))
                  0: ew = enc_r(32, rs2p, rdp, 0, rdp, 'h33);
                  1: ew = enc_r(0, rs2p, rdp, 4, rdp, 'h33);
                  2: ew = enc_r(0, rs2p, rdp, 6, rdp, 'h33);
                  default: ew = enc_r(0, rs2p, rdp, 7, rdp, 'h33);
                endcase
              end
            endcase
          end
        end
        1, 5: begin
          o = 2048 * int'(c[12]) + 16 * int'(c[11]) + 256 * int'(c[10:9]) + 1024 * int'(c[8])
            + 64 * int'(c[7]) + 128 * int'(c[6]) + 2 * int'(c[5:3]) + 32 * int'(c[2]);
          if (c[12]) o = o - 4096;
          ew = enc_j(o, (f3 == 1) ? 1 : 0); ill = 0; tag = "R11 jal";
        end
        default: begin
          o = 256 * int'(c[12]) + 8 * int'(c[11:10]) + 64 * int'(c[6:5]) + 2 * int'(c[4:3])
            + 32 * int'(c[2]);
          if (c[12]) o = o - 512;
          ew = enc_b(o, rdp, (f3 == 6) ? 0 : 1); ill = 0; tag = "R10 R2 branch";
        end
      endcase
    end else begin
      if (f3 == 0 && !c[12]) begin
        ew = enc_r(0, rs2, rd, 1, rd, 'h13); ill = 0; tag = "R7 slli";
      end else if (f3 == 4) begin
        if (rs2 != 0) begin
          ew = enc_r(0, rs2, c[12] ? rd : 0, 0, rd, 'h33); ill = 0;
          tag = c[12] ? "R4 add" : "R3 mv";
        end else if (rd != 0) begin
          ew = enc_i(0, rd, 0, c[12] ? 1 : 0, 'h67); ill = 0;
          tag = c[12] ? "R4 jalr" : "R3 jr";
        end else tag = c[12] ? "R12 R4 zero" : "R12 R3 zero";
      end
    end
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // at a negedge: compare the pending result, then present a new word
  task automatic step(input logic [31:0] w, input logic v);
    if (pend)
      check(exp_tag, out_valid === 1'b1 && out_word === exp_w && out_illegal === exp_i,
            {out_word[30:0], out_illegal}, {exp_w[30:0], exp_i});
    in_word  = w;
    in_valid = v;
    pend     = v;
    if (v) ref_exp(w, exp_w, exp_i, exp_tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14: empty during reset
    check("R14 reset", out_valid === 1'b0 && in_ready === 1'b1, {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R14 after reset", out_valid === 1'b0 && in_ready === 1'b1, {31'd0, out_valid}, 32'd0);

    // known worked examples, each with a fixed expected word
    step(32'h0000_15fd, 1'b1);
    check("R5 addi x11,x11,-1", exp_w === 32'hfff58593, exp_w, 32'hfff58593);
    step(32'h0000_92aa, 1'b1);
    check("R4 add x5,x5,x10", exp_w === 32'h00a282b3, exp_w, 32'h00a282b3);
    step(32'h0000_8516, 1'b1);
    check("R3 mv x10,x5", exp_w === 32'h00500533, exp_w, 32'h00500533);
    step(32'h0000_8082, 1'b1);
    check("R3 jr x1", exp_w === 32'h00008067, exp_w, 32'h00008067);
    step(32'hfe05_dee3, 1'b1);
    check("R1 branch word", exp_w === 32'hfe05dee3, exp_w, 32'hfe05dee3);

    // full sweep of the low half-word
    for (int k = 0; k < 65536; k++)
      step({~k[15:0], k[15:0]}, 1'b1);
    step(32'd0, 1'b0);

    // R13: back-pressure holds the output and blocks input
    step(32'h0000_4501, 1'b1);
    if (pend)
      check(exp_tag, out_valid === 1'b1 && out_word === exp_w, out_word, exp_w);
    pend = 1'b0;
    out_ready = 1'b0;
    in_word   = 32'h0000_0505;
    in_valid  = 1'b1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      check("R13 stall hold", out_valid === 1'b1 && in_ready === 1'b0 && out_word === exp_w,
            out_word, exp_w);
    end
    out_ready = 1'b1;
    @(negedge clk);
    ref_exp(32'h0000_0505, exp_w, exp_i, exp_tag);
    check("R13 release", out_valid === 1'b1 && out_word === exp_w, out_word, exp_w);
    in_valid = 1'b0;
    @(negedge clk);
    check("R13 drain", out_valid === 1'b0, {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule